// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block owns the micro program counter of a microprogrammed processor and decides, every clock, which control-store word runs next. There is no incrementer: each microinstruction names its own successor, and the sequencer only bends that address. Two ALU condition flags (negative and zero) are held in flip-flops at the end of the cycle that produced them. A microinstruction may ask for either flag to be OR-ed into the top address bit, which gives a two-way branch between a word and its partner 256 words above it.

A separate dispatch bit ORs the 8-bit opcode byte, fetched at the ISA level, into the low eight address bits. Each ISA instruction's microroutine sits at the control-store word whose address equals its opcode. When the successor field's low byte is zero, decode therefore takes a single microcycle, with no compare chain and no adder. The control-store ROM, the ALU and memory sit outside the block. It only receives the fields, the flags and the opcode byte, and it returns the address.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `mseq_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and both held flags (`neg_held`, `zero_held`) are 0, regardless of the other inputs.
- R2: `upc` changes only at a rising edge of `clk`. When `br_neg`, `br_zero` and `dispatch` are all 0, the value loaded is exactly `succ_addr`.
- R3: Bit 8 of the loaded address is `succ_addr[8] | (br_zero & zero_held) | (br_neg & neg_held)`.
- R4: The next-address logic uses only the held flags. `neg_held`/`zero_held` take the values of `alu_neg`/`alu_zero` at each rising edge, so a flag raised in the same cycle as a branch request does not steer that branch.
- R5: When `dispatch` is 1, bits 7..0 of the loaded address are `succ_addr[7:0] | opcode`. Bit 8 still follows R3.
- R6: When `dispatch` is 0, `opcode` has no effect on the loaded address.
- R7: With `succ_addr[7:0]` equal to 0 and `dispatch` set, `upc[7:0]` equals the opcode one edge later, so the routine at the opcode's address is entered in one microcycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| succ_addr | input | 9 | Successor address field of the current microinstruction |
| br_neg | input | 1 | OR the held negative flag into the top address bit |
| br_zero | input | 1 | OR the held zero flag into the top address bit |
| dispatch | input | 1 | OR the opcode byte into the low address bits |
| opcode | input | 8 | Opcode byte from the instruction-fetch register |
| alu_neg | input | 1 | ALU result negative, this cycle |
| alu_zero | input | 1 | ALU result zero, this cycle |
| upc | output | 9 | Micro program counter, the address of the word now executing |
| neg_held | output | 1 | Registered negative flag |
| zero_held | output | 1 | Registered zero flag |

## Verification
Every fault in this block appears on `upc` at the very next rising edge, because the counter reloads each cycle from its inputs and keeps no history beyond the two flags. A flag latched wrongly, or a flag taken straight from the ALU instead of the latch, shows as a wrong top bit exactly one edge after the branch request. The bench therefore sets flags one cycle before the branch that uses them, and also in the same cycle as that branch. A bad OR into the low byte shows as a wrong dispatch target on the same edge, and a stuck counter bit shows on any vector that should set it.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int MSEQ_ADDR_W = 9;
  localparam int MSEQ_OP_W   = 8;

  typedef struct packed {
    logic br_neg;
    logic br_zero;
    logic dispatch;
  } mseq_ctl_t;

  typedef struct packed {
    logic neg;
    logic zero;
  } mseq_flags_t;
endpackage

// File: rtl/mseq_flag_reg.sv
module mseq_flag_reg
  import mseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  mseq_flags_t flags_in,
  output mseq_flags_t flags_q
);
  localparam int NFLAG = $bits(mseq_flags_t);

  logic [NFLAG-1:0] d_vec, q_vec;
  assign d_vec   = flags_in;
  assign flags_q = q_vec;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_vec[g] <= 1'b0;
      else        q_vec[g] <= d_vec[g];
    end
  end

  p_flag_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flags_q == $past(flags_in));
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
  import mseq_pkg::*;
#(
  parameter int ADDR_W = MSEQ_ADDR_W,
  parameter int OP_W   = MSEQ_OP_W
) (
  input  logic [ADDR_W-1:0] succ_addr,
  input  mseq_ctl_t         ctl,
  input  mseq_flags_t       flags,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int LOW_W = ADDR_W - 1;

  logic [LOW_W-1:0] op_ext;
  logic [LOW_W-1:0] low_part;
  logic             jam_bit;

  assign op_ext = LOW_W'(opcode);

  always_comb begin
    low_part = succ_addr[LOW_W-1:0];
    if (ctl.dispatch) low_part = low_part | op_ext;
    jam_bit = (ctl.br_zero & flags.zero) | (ctl.br_neg & flags.neg);
    next_addr = {succ_addr[ADDR_W-1] | jam_bit, low_part};
  end

  initial begin
    assert (OP_W <= LOW_W);
  end
endmodule

// File: rtl/mseq_pc_reg.sv
module mseq_pc_reg #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> q == '0);
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
  import mseq_pkg::*;
#(
  parameter int ADDR_W = MSEQ_ADDR_W,
  parameter int OP_W   = MSEQ_OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] succ_addr,
  input  logic              br_neg,
  input  logic              br_zero,
  input  logic              dispatch,
  input  logic [OP_W-1:0]   opcode,
  input  logic              alu_neg,
  input  logic              alu_zero,
  output logic [ADDR_W-1:0] upc,
  output logic              neg_held,
  output logic              zero_held
);
  localparam int LOW_W = ADDR_W - 1;

  mseq_ctl_t   ctl;
  mseq_flags_t flags_now, flags_q;
  logic [ADDR_W-1:0] nxt;

  assign ctl       = '{br_neg: br_neg, br_zero: br_zero, dispatch: dispatch};
  assign flags_now = '{neg: alu_neg, zero: alu_zero};
  assign neg_held  = flags_q.neg;
  assign zero_held = flags_q.zero;

  mseq_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_in (flags_now),
    .flags_q  (flags_q)
  );

  mseq_next_addr #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_next (
    .succ_addr (succ_addr),
    .ctl       (ctl),
    .flags     (flags_q),
    .opcode    (opcode),
    .next_addr (nxt)
  );

  mseq_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (upc)
  );

  p_flags_reset_r1: assert property (@(posedge clk) !rst_n |-> !neg_held && !zero_held);

  p_plain_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_neg && !br_zero && !dispatch) |=> upc == $past(succ_addr));

  p_jam_sets_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((br_zero && zero_held) || (br_neg && neg_held)) |=> upc[ADDR_W-1]);

  p_no_jam_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!succ_addr[ADDR_W-1] && !(br_zero && zero_held) && !(br_neg && neg_held))
      |=> !upc[ADDR_W-1]);

  p_dispatch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> upc[LOW_W-1:0] == ($past(succ_addr[LOW_W-1:0]) | LOW_W'($past(opcode))));

  p_opcode_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> upc[LOW_W-1:0] == $past(succ_addr[LOW_W-1:0]));
endmodule

// File: tb/mseq_sequencer_tb_top.sv
module mseq_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] succ_addr = '0;
  logic       br_neg = 1'b0, br_zero = 1'b0, dispatch = 1'b0;
  logic [7:0] opcode = '0;
  logic       alu_neg = 1'b0, alu_zero = 1'b0;
  logic [8:0] upc;
  logic       neg_held, zero_held;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mseq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .succ_addr(succ_addr), .br_neg(br_neg),
    .br_zero(br_zero), .dispatch(dispatch), .opcode(opcode),
    .alu_neg(alu_neg), .alu_zero(alu_zero), .upc(upc),
    .neg_held(neg_held), .zero_held(zero_held)
  );

  // vector: {alu_neg, alu_zero, br_neg, br_zero, dispatch, succ[8:0], opcode[7:0]}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {5'b00000, 9'h0A5, 8'hFF},
    {5'b10100, 9'h012, 8'h00},
    {5'b00100, 9'h012, 8'h00},
    {5'b01010, 9'h034, 8'h00},
    {5'b00010, 9'h034, 8'h00},
    {5'b11110, 9'h056, 8'h00},
    {5'b10010, 9'h056, 8'h00},
    {5'b01100, 9'h078, 8'h00},
    {5'b00001, 9'h000, 8'h36},
    {5'b00001, 9'h000, 8'hA7},
    {5'b00001, 9'h0F0, 8'h0F},
    {5'b10101, 9'h000, 8'h59},
    {5'b01011, 9'h000, 8'hC3},
    {5'b00001, 9'h100, 8'h01}
  };

  function automatic logic [8:0] model(input logic n, input logic z,
                                       input logic jn, input logic jz, input logic jd,
                                       input logic [8:0] sa, input logic [7:0] op);
    logic [7:0] lo;
    lo = jd ? (sa[7:0] | op) : sa[7:0];
    return {sa[8] | (jz & z) | (jn & n), lo};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    alu_neg = 1'b1; alu_zero = 1'b1; succ_addr = 9'h1FF; dispatch = 1'b1; opcode = 8'hFF;
    tick(); tick();
    // R1: reset state
    check("R1 upc", upc, 9'h000);
    check("R1 flags", {7'd0, neg_held, zero_held}, 9'h000);
    alu_neg = 0; alu_zero = 0; succ_addr = 0; dispatch = 0; opcode = 0;
    @(negedge clk); rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      alu_neg = v[21]; alu_zero = v[20];
      br_neg = 0; br_zero = 0; dispatch = 0; succ_addr = 0;
      tick();
      // R4: held flags follow the ALU at the edge
      check("R4 flag capture", {7'd0, neg_held, zero_held}, {7'd0, v[21], v[20]});
      br_neg = v[19]; br_zero = v[18]; dispatch = v[17];
      succ_addr = v[16:8]; opcode = v[7:0];
      tick();
      // R2/R3/R5/R6/R7: loaded address
      check("R2 R3 R5 R6 R7 next address", upc,
            model(v[21], v[20], v[19], v[18], v[17], v[16:8], v[7:0]));
    end

    // R4: flag raised in the same cycle as the branch does not steer it
    alu_neg = 0; alu_zero = 0; br_neg = 0; br_zero = 0; dispatch = 0; succ_addr = 0;
    tick();
    alu_neg = 1; br_neg = 1; succ_addr = 9'h010;
    tick();
    check("R4 same-cycle flag", upc, 9'h010);
    tick();
    check("R4 flag next cycle", upc, 9'h110);

    // R6: opcode ignored without dispatch
    alu_neg = 0; br_neg = 0; succ_addr = 9'h055; opcode = 8'hAA;
    tick(); tick();
    check("R6 opcode ignored", upc, 9'h055);

    // R7: one-cycle decode to opcode address
    succ_addr = 9'h000; dispatch = 1; opcode = 8'h9C;
    tick();
    check("R7 decode", upc, 9'h09C);

    // R2: no change between edges
    dispatch = 0; succ_addr = 9'h1E1;
    @(negedge clk);
    check("R2 hold between edges", upc, 9'h09C);
    tick();
    check("R2 load at edge", upc, 9'h1E1);

    // R1: asynchronous reset mid-run
    alu_neg = 1; alu_zero = 1;
    tick();
    @(negedge clk); rst_n = 0; #1;
    check("R1 async upc", upc, 9'h000);
    check("R1 async flags", {7'd0, neg_held, zero_held}, 9'h000);
    tick();
    check("R1 held in reset", upc, 9'h000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule